// File: doc/BRIEF.md
# Dual-Mode Host Parallel Port Strobe Front End

This block is the slave-side front end of a 16-bit parallel host port. It accepts hosts that use separate read and write strobes, and hosts that use a single data strobe together with a read/write line. Every host pin is asynchronous to the system clock. The block passes each pin through a multi-flop synchronizer. It then merges chip select and the two strobe pins into one active-low combined strobe, and watches that strobe for edges.

A falling edge of the combined strobe opens a transaction and produces a one-cycle start pulse. A rising edge closes the transaction and produces a one-cycle end pulse. Both pulses are tagged read or write. For a read, the block asks the internal register side for a word at the start. It registers the answer and drives it toward the pad with an output enable until the strobe closes. For a write, the block takes the synchronized data bus at the close and hands it to the register side with a one-cycle write pulse.

The read/write direction is fixed for the whole access when the access opens. If the read/write line moves while the strobe is asserted, a sticky protocol-error flag is set.

Top module: `hostStrobePort`

## Requirements
- R1: The combined strobe is asserted when chip select is low and the two strobe pins are at different levels. It is negated whenever chip select is high or the two strobe pins are equal. With chip select low and both strobe pins low, no transaction starts.
- R2: Each access produces exactly one `xferStart` pulse and one `xferEnd` pulse, each one cycle long. A strobe-pin change applied just after a clock edge shows on the pulse output after the second following rising edge, because of the two-flop synchronizer.
- R3: While chip select is high, activity on either strobe pin, the read/write line or the data bus produces no pulse, no register request and no output enable.
- R4: Direction decoding works in three host styles. In separate-strobe style, the output strobe pin going low is a read, and the input strobe pin going low (with the read/write line tied to it) is a write. In single-strobe style, the output strobe pin is the data strobe: it is active high when the input strobe pin is held at 0 and active low when it is held at 1. The read/write line selects the direction: 1 means read, 0 means write.
- R5: On a read, `regRdReq` pulses for one cycle in the same cycle as `xferStart`. `regRdData` is registered in the following cycle, and `hostDataOe` rises one cycle after that with the registered word on `hostDataOut`.
- R6: `hostDataOe` stays high until the `xferEnd` cycle inclusive and is low in the cycle after `xferEnd`. It is never high on a write.
- R7: On a write, the synchronized data bus is captured at `xferEnd`. `regWrReq` pulses for one cycle in the cycle after `xferEnd`, with the captured word on `regWrData`.
- R8: `xferRead` gives the direction sampled at the start of the access and keeps it for the whole access. A change of the read/write line while the strobe is asserted sets `protoErr`, which then stays high. Such a change does not alter the access direction.
- R9: Synchronous active-high reset clears the edge-detect state and `hostDataOe`, and clears `protoErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hostCsN | input | 1 | Host chip select, active low, asynchronous |
| hostOutStb | input | 1 | Output (read) strobe pin, or the data strobe in single-strobe style |
| hostInStb | input | 1 | Input (write) strobe pin, or the polarity select in single-strobe style |
| hostRdWr | input | 1 | Read/write line: 1 means read, 0 means write |
| hostDataIn | input | 16 | Data bus as seen from the pad input |
| hostDataOut | output | 16 | Read data toward the pad driver |
| hostDataOe | output | 1 | Pad output enable; the bus is tristated when low |
| regRdReq | output | 1 | One-cycle internal read request |
| regRdData | input | 16 | Internal read data, valid the cycle after `regRdReq` |
| regWrReq | output | 1 | One-cycle internal write request |
| regWrData | output | 16 | Captured write data |
| xferStart | output | 1 | Transaction-start pulse |
| xferEnd | output | 1 | Transaction-end pulse |
| xferRead | output | 1 | Direction tag of the current access |
| protoErr | output | 1 | Sticky protocol-error flag |

## Verification
The bench sweeps all three host styles and both directions over several data patterns, and measures pulse counts, pulse latency, output-enable length and the data that reaches each side. It drives chip select low with both strobe pins equal, including both low. A design that used the plain XOR form, or that ignored chip select, would start a transaction there or fail to start one in a real access. It toggles every pin with chip select high, where a leaky design would show pulses or enable the bus. It moves the read/write line in the middle of a read and checks three things: the error flag sets and stays set, no write is issued, and only reset clears the flag. A design that re-sampled the direction at the end would issue a spurious write.

// File: rtl/hspPkg.sv
package hspPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadRd;   // register the internal read word
    logic loadWr;   // capture the synchronized bus word
  } ctlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic fall;        // combined strobe asserted this cycle
    logic rise;        // combined strobe released this cycle
    logic rwLvl;       // synchronized read/write line
    logic strbActive;  // combined strobe currently asserted
  } strbStat_t;
endpackage

// File: rtl/hspSync.sv
module hspSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hspDatapath.sv
module hspDatapath
  import hspPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              outStb,
  input  logic              inStb,
  input  logic              rdWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] regRdData,
  input  ctlStrb_t          ctl,
  output strbStat_t         stat,
  output logic [DATA_W-1:0] holdData,
  output logic [DATA_W-1:0] wrData
);
  localparam int PIN_W = 4;

  logic [PIN_W-1:0]  pinRaw, pinSync;
  logic [DATA_W-1:0] dataSync;
  logic csS, outS, inS, rwS;
  logic strbN, prevStrbN;

  assign pinRaw = {csN, outStb, inStb, rdWr};

  hspSync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL({PIN_W{1'b1}})) uPinSync (
    .clk(clk), .rst(rst), .d(pinRaw), .q(pinSync)
  );

  // data travels through the same depth so it stays aligned with the strobe
  hspSync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) uDataSync (
    .clk(clk), .rst(rst), .d(dataIn), .q(dataSync)
  );

  assign {csS, outS, inS, rwS} = pinSync;

  // asserted (low) when selected and the two strobe pins disagree
  assign strbN = csS | ~(inS ^ outS);

  always_ff @(posedge clk) begin
    if (rst) prevStrbN <= 1'b1;
    else     prevStrbN <= strbN;
  end

  always_comb begin
    stat.fall       = prevStrbN & ~strbN;
    stat.rise       = ~prevStrbN & strbN;
    stat.rwLvl      = rwS;
    stat.strbActive = ~strbN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdData <= '0;
      wrData   <= '0;
    end else begin
      if (ctl.loadRd) holdData <= regRdData;
      if (ctl.loadWr) wrData   <= dataSync;
    end
  end
endmodule

// File: rtl/hspControl.sv
module hspControl
  import hspPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  strbStat_t stat,
  output ctlStrb_t  ctl,
  output logic      xferStart,
  output logic      xferEnd,
  output logic      xferRead,
  output logic      regRdReq,
  output logic      regWrReq,
  output logic      dataOe,
  output logic      protoErr
);
  logic active, dirRd, rdPend, wrPulse;

  assign xferStart = stat.fall;
  assign xferEnd   = stat.rise & active;
  assign xferRead  = stat.fall ? stat.rwLvl : dirRd;
  assign regRdReq  = stat.fall & stat.rwLvl;
  assign regWrReq  = wrPulse;

  always_comb begin
    ctl.loadRd = rdPend;
    ctl.loadWr = xferEnd & ~dirRd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      dirRd    <= 1'b0;
      rdPend   <= 1'b0;
      dataOe   <= 1'b0;
      wrPulse  <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (stat.fall) begin
        active <= 1'b1;
        dirRd  <= stat.rwLvl;
      end else if (xferEnd) begin
        active <= 1'b0;
      end
      rdPend  <= regRdReq;
      wrPulse <= ctl.loadWr;
      if (xferEnd)               dataOe <= 1'b0;
      else if (rdPend && active) dataOe <= 1'b1;
      if (active && stat.strbActive && (stat.rwLvl != dirRd))
        protoErr <= 1'b1;
    end
  end
endmodule

// File: rtl/hostStrobePort.sv
module hostStrobePort
  import hspPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostCsN,
  input  logic              hostOutStb,
  input  logic              hostInStb,
  input  logic              hostRdWr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              regRdReq,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrReq,
  output logic [DATA_W-1:0] regWrData,
  output logic              xferStart,
  output logic              xferEnd,
  output logic              xferRead,
  output logic              protoErr
);
  ctlStrb_t  ctl;
  strbStat_t stat;

  hspDatapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rst(rst),
    .csN(hostCsN), .outStb(hostOutStb), .inStb(hostInStb), .rdWr(hostRdWr),
    .dataIn(hostDataIn), .regRdData(regRdData),
    .ctl(ctl), .stat(stat),
    .holdData(hostDataOut), .wrData(regWrData)
  );

  hspControl uCtl (
    .clk(clk), .rst(rst), .stat(stat), .ctl(ctl),
    .xferStart(xferStart), .xferEnd(xferEnd), .xferRead(xferRead),
    .regRdReq(regRdReq), .regWrReq(regWrReq),
    .dataOe(hostDataOe), .protoErr(protoErr)
  );
endmodule

// File: rtl/hostStrobePortChk.sv
module hostStrobePortChk (
  input logic clk,
  input logic rst,
  input logic hostDataOe,
  input logic regRdReq,
  input logic regWrReq,
  input logic xferStart,
  input logic xferEnd,
  input logic xferRead,
  input logic protoErr
);
  AST_START_END_APART: assert property (@(posedge clk) disable iff (rst) !(xferStart && xferEnd)); // R2
  AST_RDREQ_WITH_START: assert property (@(posedge clk) disable iff (rst) regRdReq |-> (xferStart && xferRead)); // R5
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst) hostDataOe |-> xferRead); // R6
  AST_OE_DROP_AFTER_END: assert property (@(posedge clk) disable iff (rst) xferEnd |=> !hostDataOe); // R6
  AST_WR_AFTER_END: assert property (@(posedge clk) disable iff (rst) regWrReq |-> $past(xferEnd && !xferRead)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) protoErr |=> protoErr); // R8
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({regRdReq, regWrReq})); // R5
endmodule

bind hostStrobePort hostStrobePortChk uChk (
  .clk(clk), .rst(rst), .hostDataOe(hostDataOe),
  .regRdReq(regRdReq), .regWrReq(regWrReq),
  .xferStart(xferStart), .xferEnd(xferEnd), .xferRead(xferRead),
  .protoErr(protoErr)
);

// File: tb/tb_hostStrobePort.sv
module tb_hostStrobePort;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostCsN = 1'b1, hostOutStb = 1'b1, hostInStb = 1'b1, hostRdWr = 1'b1;
  logic [15:0] hostDataIn = '0, regRdData = '0;
  logic [15:0] hostDataOut, regWrData;
  logic hostDataOe, regRdReq, regWrReq, xferStart, xferEnd, xferRead, protoErr;

  hostStrobePort dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  int cyc = 0;
  bit done = 0;

  // monitor state
  bit monOn = 0;
  int nStart, nEnd, nRdReq, nWr, nOe, oeLate, startCyc, endCyc, wrCyc;
  bit startTag, endPrev;
  logic [15:0] oeData, wrSeen;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (monOn) begin
      if (endPrev && hostDataOe) oeLate++;
      endPrev = xferEnd;
      if (xferStart) begin nStart++; startCyc = cyc; startTag = xferRead; end
      if (xferEnd) begin nEnd++; endCyc = cyc; end
      if (regRdReq) nRdReq++;
      if (regWrReq) begin nWr++; wrSeen = regWrData; wrCyc = cyc; end
      if (hostDataOe) begin nOe++; oeData = hostDataOut; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic monClear();
    nStart = 0; nEnd = 0; nRdReq = 0; nWr = 0; nOe = 0; oeLate = 0;
    startCyc = 0; endCyc = 0; wrCyc = 0; startTag = 0; endPrev = 0;
    oeData = '0; wrSeen = '0;
  endtask

  // mode 0: separate strobes, 1: single strobe active high, 2: single strobe active low
  task automatic setIdle(input int mode);
    hostCsN = 1'b1;
    case (mode)
      0: begin hostOutStb = 1'b1; hostInStb = 1'b1; hostRdWr = 1'b1; end
      1: begin hostOutStb = 1'b0; hostInStb = 1'b0; end
      default: begin hostOutStb = 1'b1; hostInStb = 1'b1; end
    endcase
  endtask

  task automatic access(input int mode, input bit rd, input logic [15:0] data);
    int driveCyc;
    @(negedge clk);
    setIdle(mode);
    repeat (4) @(negedge clk);
    monClear();
    monOn = 1;
    regRdData = data;
    hostDataIn = data;
    if (mode != 0) hostRdWr = rd;
    hostCsN = 1'b0;
    repeat (2) @(negedge clk);
    case (mode)
      0: if (rd) hostOutStb = 1'b0; else begin hostInStb = 1'b0; hostRdWr = 1'b0; end
      default: hostOutStb = ~hostOutStb;
    endcase
    driveCyc = cyc;
    repeat (HOLD) @(negedge clk);
    case (mode)
      0: begin hostOutStb = 1'b1; hostInStb = 1'b1; hostRdWr = 1'b1; end
      default: hostOutStb = ~hostOutStb;
    endcase
    repeat (4) @(negedge clk);
    hostCsN = 1'b1;
    repeat (3) @(negedge clk);
    monOn = 0;
    chk(nStart == 1, "R2 start count", nStart, 1);
    chk(nEnd == 1, "R2 end count", nEnd, 1);
    chk(startCyc - driveCyc == 2, "R2 start latency", startCyc - driveCyc, 2);
    chk(startTag == rd, "R4 direction tag", startTag, rd);
    chk(protoErr == 1'b0, "R8 no error on clean access", protoErr, 0);
    if (rd) begin
      chk(nRdReq == 1, "R5 read request", nRdReq, 1);
      chk(oeData == data, "R5 read data on bus", oeData, data);
      chk(nOe == HOLD - 1, "R6 enable length", nOe, HOLD - 1);
      chk(oeLate == 0, "R6 enable off after end", oeLate, 0);
      chk(nWr == 0, "R7 no write on read", nWr, 0);
    end else begin
      chk(nWr == 1, "R7 write pulse", nWr, 1);
      chk(wrSeen == data, "R7 write data", wrSeen, data);
      chk(wrCyc - endCyc == 1, "R7 write latency", wrCyc - endCyc, 1);
      chk(nOe == 0, "R6 no enable on write", nOe, 0);
      chk(nRdReq == 0, "R5 no read request on write", nRdReq, 0);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    setIdle(0);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(hostDataOe == 1'b0, "R9 oe in reset", hostDataOe, 0);
    chk(protoErr == 1'b0, "R9 error in reset", protoErr, 0);
    chk(xferStart == 1'b0 && xferEnd == 1'b0, "R9 no pulses in reset", xferStart, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: selected, both strobe pins low (equal) -> no transaction
    monClear(); monOn = 1;
    hostCsN = 1'b0; hostOutStb = 1'b0; hostInStb = 1'b0;
    repeat (8) @(negedge clk);
    hostOutStb = 1'b1; hostInStb = 1'b1;
    repeat (6) @(negedge clk);
    hostCsN = 1'b1;
    repeat (4) @(negedge clk);
    monOn = 0;
    chk(nStart == 0, "R1 equal strobes inactive", nStart, 0);
    chk(nOe == 0 && nRdReq == 0, "R1 no request", nRdReq, 0);

    // R3: chip select high, toggle everything
    monClear(); monOn = 1;
    for (int i = 0; i < 16; i++) begin
      hostOutStb = i[0]; hostInStb = i[1]; hostRdWr = i[2];
      hostDataIn = 16'(i * 16'h1357);
      repeat (3) @(negedge clk);
    end
    setIdle(0);
    repeat (4) @(negedge clk);
    monOn = 0;
    chk(nStart == 0 && nEnd == 0, "R3 no pulses deselected", nStart + nEnd, 0);
    chk(nRdReq == 0 && nWr == 0, "R3 no requests deselected", nRdReq + nWr, 0);
    chk(nOe == 0, "R3 bus tristated deselected", nOe, 0);

    // R1 R4 R5 R6 R7 sweep over host styles, directions, data patterns
    for (int mode = 0; mode < 3; mode++)
      for (int rd = 0; rd < 2; rd++)
        for (int p = 0; p < 4; p++)
          access(mode, rd[0], 16'((16'h0001 << (p * 5)) ^ (p * 16'h2492) ^ (rd * 16'hF00F)));

    // R8: read/write line moves during an active read
    @(negedge clk);
    setIdle(2);
    repeat (3) @(negedge clk);
    monClear(); monOn = 1;
    hostRdWr = 1'b1; hostCsN = 1'b0;
    repeat (2) @(negedge clk);
    hostOutStb = 1'b0;
    repeat (5) @(negedge clk);
    hostRdWr = 1'b0;
    repeat (5) @(negedge clk);
    hostOutStb = 1'b1;
    repeat (4) @(negedge clk);
    hostCsN = 1'b1;
    repeat (3) @(negedge clk);
    monOn = 0;
    chk(protoErr == 1'b1, "R8 error set", protoErr, 1);
    chk(nRdReq == 1 && nWr == 0, "R8 direction held", nWr, 0);
    chk(startTag == 1'b1, "R8 tag read", startTag, 1);

    // R8 sticky across a clean access
    @(negedge clk);
    setIdle(1);
    hostRdWr = 1'b0; hostCsN = 1'b0;
    repeat (2) @(negedge clk);
    hostOutStb = 1'b1;
    repeat (6) @(negedge clk);
    hostOutStb = 1'b0;
    repeat (4) @(negedge clk);
    hostCsN = 1'b1;
    repeat (3) @(negedge clk);
    chk(protoErr == 1'b1, "R8 error sticky", protoErr, 1);

    // R9 reset clears error
    doReset();
    @(negedge clk);
    chk(protoErr == 1'b0, "R9 error cleared", protoErr, 0);
    chk(hostDataOe == 1'b0, "R9 oe after reset", hostDataOe, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule